// File: doc/BRIEF.md
# Long-Press Staged Reset Sequencer

This block turns a sustained press on either of two active-low keys (a power key and a secondary reset key) into an escalating reset. Each key has its own two-step hold timer. When the first step expires, the block gives a one-cycle warning (bark) pulse. When the second step then expires, it issues a reset request that carries the reset type configured for that key. A third, independent path counts whole seconds of hold on a selectable key combination and then forces a hard reset no matter how the per-key paths are set up. A cable-power input produces only a power-on event and can never cause a reset.

All timers advance on a 1 kHz tick enable. The seconds used by the third stage are derived inside the block from that tick. Every request sets a bit in a sticky reason register. The bit records which key, or the third stage, caused it. The host clears bits by writing ones. The configuration inputs are meant to be driven from a register bank elsewhere. The third-stage select encodes "both keys" as zero, so an all-zero reset state of that bank gives the AND combination.

Top module: `lpr_seq`

## Requirements
- R1: With the tick high on every cycle, a held key whose reset enable is set raises its bark pulse exactly T1+4 clock cycles after its input falls. T1 is selected by the 4-bit stage-1 index from {0,32,56,80,128,184,272,408,608,904,1352,2048,3072,4480,6720,10256} ticks.
- R2: A key that is still held produces one reset request exactly T1+T2+6 cycles after its input falls. T2 is selected by the 3-bit stage-2 index from {0,10,50,100,250,500,1000,2000} ticks. A key gives at most one request per press.
- R3: A request from a key presents that key's 3-bit type code on rst_type in the same cycle (soft 0, warm 1, shutdown 4, hard 7). Stage-3 requests always present 7.
- R4: Releasing a key before its stage-2 expiry returns it to idle with no request. A later press restarts both timers from zero.
- R5: With a key's reset enable clear, the key never barks and never requests a reset. Its press and release events still occur.
- R6: The stage-3 select encodes 0 = both keys (AND), 1 = either key (OR), 2 = power key only, 3 = reset key only. With the selected condition held for H seconds, a request of type 7 arrives H*TICKS_PER_SEC+4 cycles after the condition becomes true at the inputs. The request fires once per continuous hold.
- R7: Timers advance only on cycles where the tick is high. With the tick low, a pressed key does not progress. Once ticking resumes from a count of zero, the bark comes T1+1 cycles later.
- R8: When both keys have passed stage 1, combo_bark pulses once, in the same cycle as the bark of the later key.
- R9: The reason register sets bit 0 for a power-key stage-2 request, bit 1 for a reset-key stage-2 request and bit 2 for a stage-3 request. Bits persist until a 1 is written to the same bit of reason_clr. Writing 0 leaves a bit unchanged.
- R10: When requests coincide, stage 3 wins over the power key, and the power key wins over the reset key. Only the winner's type and reason bit are applied, and a single request is issued.
- R11: A falling cable-power input gives a one-cycle pon_evt 3 cycles later and never a reset request.
- R12: Bark, key_press and key_release are one-cycle pulses. A key's press event appears 3 cycles after its input falls, and its release event appears 3 cycles after the input rises.
- R13: A stage-3 hold value above 128 seconds acts as 128 seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | 1 kHz timer enable |
| pwr_key_n | input | 1 | Power key, active low, asynchronous |
| rst_key_n | input | 1 | Secondary reset key, active low, asynchronous |
| cbl_pwr_n | input | 1 | Cable power detect, active low, asynchronous |
| pk_rst_en | input | 1 | Power key reset enable |
| pk_s1_sel | input | 4 | Power key stage-1 index |
| pk_s2_sel | input | 3 | Power key stage-2 index |
| pk_rtype | input | 3 | Power key reset type code |
| rk_rst_en | input | 1 | Reset key reset enable |
| rk_s1_sel | input | 4 | Reset key stage-1 index |
| rk_s2_sel | input | 3 | Reset key stage-2 index |
| rk_rtype | input | 3 | Reset key reset type code |
| s3_sel | input | 2 | Stage-3 key combination |
| s3_hold_s | input | 8 | Stage-3 hold time in seconds |
| reason_clr | input | 3 | Write-one-to-clear strobe for the reason bits |
| key_press | output | 2 | Press event pulses (bit 0 power key, bit 1 reset key) |
| key_release | output | 2 | Release event pulses |
| bark | output | 2 | Stage-1 warning pulses |
| combo_bark | output | 1 | Both-keys warning pulse |
| pon_evt | output | 1 | Cable power-on event pulse |
| rst_req | output | 1 | Reset request pulse |
| rst_type | output | 3 | Reset type that goes with rst_req |
| reason | output | 3 | Sticky reset reason |

## Verification
The bench builds the block with TICKS_PER_SEC set to 10 and holds the tick high on most cycles. Each millisecond step therefore costs one clock, and one stage-3 second costs ten. This brings the longest stage-1 entry, the 128-second stage-3 ceiling and the clamp above it within a short run. Expected arrival cycles come from the tables and latency formulas in the requirements. A directed phase with the tick held low checks that the timers stall.

// File: rtl/lpr_pkg.sv
`timescale 1ns/1ps
package lpr_pkg;

  localparam int NKEY   = 2;
  localparam int KEY_PK = 0;
  localparam int KEY_RK = 1;
  localparam int CNT_W  = 14;

  localparam logic [2:0] RT_HARD = 3'd7;

  localparam logic [1:0] S3_BOTH   = 2'd0;
  localparam logic [1:0] S3_EITHER = 2'd1;
  localparam logic [1:0] S3_PK     = 2'd2;
  localparam logic [1:0] S3_RK     = 2'd3;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_S1   = 2'd1,
    K_S2   = 2'd2,
    K_HOLD = 2'd3
  } key_st_e;

  typedef struct packed {
    logic       rst_en;
    logic [3:0] s1_sel;
    logic [2:0] s2_sel;
    logic [2:0] rtype;
  } key_cfg_t;

  function automatic logic [CNT_W-1:0] s1_ticks(input logic [3:0] idx);
    logic [CNT_W-1:0] v;
    case (idx)
      4'd0:  v = 14'd0;
      4'd1:  v = 14'd32;
      4'd2:  v = 14'd56;
      4'd3:  v = 14'd80;
      4'd4:  v = 14'd128;
      4'd5:  v = 14'd184;
      4'd6:  v = 14'd272;
      4'd7:  v = 14'd408;
      4'd8:  v = 14'd608;
      4'd9:  v = 14'd904;
      4'd10: v = 14'd1352;
      4'd11: v = 14'd2048;
      4'd12: v = 14'd3072;
      4'd13: v = 14'd4480;
      4'd14: v = 14'd6720;
      default: v = 14'd10256;
    endcase
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] s2_ticks(input logic [2:0] idx);
    logic [CNT_W-1:0] v;
    case (idx)
      3'd0: v = 14'd0;
      3'd1: v = 14'd10;
      3'd2: v = 14'd50;
      3'd3: v = 14'd100;
      3'd4: v = 14'd250;
      3'd5: v = 14'd500;
      3'd6: v = 14'd1000;
      default: v = 14'd2000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/lpr_sync.sv
`timescale 1ns/1ps
module lpr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '1;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lpr_key_fsm.sv
`timescale 1ns/1ps
module lpr_key_fsm
  import lpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       held,
  input  logic       rst_en,
  input  logic [3:0] s1_sel,
  input  logic [2:0] s2_sel,
  output logic       press_evt,
  output logic       release_evt,
  output logic       bark,
  output logic       fire,
  output logic       armed
);
  key_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             press_d, rel_d, bark_d, fire_d;
  logic [CNT_W-1:0] s1_lim, s2_lim;

  assign s1_lim = s1_ticks(s1_sel);
  assign s2_lim = s2_ticks(s2_sel);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    press_d = 1'b0;
    rel_d   = 1'b0;
    bark_d  = 1'b0;
    fire_d  = 1'b0;
    case (st_q)
      K_IDLE: begin
        if (held) begin
          st_d    = K_S1;
          cnt_d   = '0;
          press_d = 1'b1;
        end
      end
      K_S1: begin
        if (!held) begin
          st_d  = K_IDLE;
          cnt_d = '0;
          rel_d = 1'b1;
        end else if (rst_en) begin
          if (cnt_q == s1_lim) begin
            st_d   = K_S2;
            cnt_d  = '0;
            bark_d = 1'b1;
          end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      K_S2: begin
        if (!held) begin
          st_d  = K_IDLE;
          cnt_d = '0;
          rel_d = 1'b1;
        end else if (cnt_q == s2_lim) begin
          st_d   = K_HOLD;
          cnt_d  = '0;
          fire_d = 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (!held) begin
          st_d  = K_IDLE;
          rel_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= K_IDLE;
      cnt_q       <= '0;
      press_evt   <= 1'b0;
      release_evt <= 1'b0;
      bark        <= 1'b0;
      fire        <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      press_evt   <= press_d;
      release_evt <= rel_d;
      bark        <= bark_d;
      fire        <= fire_d;
    end
  end

  assign armed = (st_q == K_S2) || (st_q == K_HOLD);
endmodule

// File: rtl/lpr_s3.sv
`timescale 1ns/1ps
module lpr_s3
  import lpr_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int S3_MAX_S      = 128,
  parameter int HOLD_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NKEY-1:0]   held,
  input  logic [1:0]        sel,
  input  logic [HOLD_W-1:0] hold_s,
  output logic              fire
);
  localparam int PRE_W = $clog2(TICKS_PER_SEC + 1);
  localparam logic [PRE_W-1:0]  PRE_TOP = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [HOLD_W-1:0] HOLD_CAP = HOLD_W'(S3_MAX_S);

  logic              cond;
  logic [HOLD_W-1:0] lim;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [HOLD_W-1:0] sec_q, sec_d;
  logic              done_q, done_d, fire_d;

  always_comb begin
    case (sel)
      S3_BOTH:   cond = held[KEY_PK] & held[KEY_RK];
      S3_EITHER: cond = held[KEY_PK] | held[KEY_RK];
      S3_PK:     cond = held[KEY_PK];
      default:   cond = held[KEY_RK];
    endcase
  end

  assign lim = (hold_s > HOLD_CAP) ? HOLD_CAP : hold_s;

  always_comb begin
    pre_d  = pre_q;
    sec_d  = sec_q;
    done_d = done_q;
    fire_d = 1'b0;
    if (!cond) begin
      pre_d  = '0;
      sec_d  = '0;
      done_d = 1'b0;
    end else begin
      if (!done_q && (sec_q == lim)) begin
        fire_d = 1'b1;
        done_d = 1'b1;
      end
      if (tick) begin
        if (pre_q == PRE_TOP) begin
          pre_d = '0;
          if (sec_q != '1) sec_d = sec_q + 1'b1;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sec_q  <= '0;
      done_q <= 1'b0;
      fire   <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      sec_q  <= sec_d;
      done_q <= done_d;
      fire   <= fire_d;
    end
  end
endmodule

// File: rtl/lpr_seq.sv
`timescale 1ns/1ps
module lpr_seq
  import lpr_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int S3_MAX_S      = 128,
  parameter int HOLD_W        = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              pwr_key_n,
  input  logic              rst_key_n,
  input  logic              cbl_pwr_n,
  input  logic              pk_rst_en,
  input  logic [3:0]        pk_s1_sel,
  input  logic [2:0]        pk_s2_sel,
  input  logic [2:0]        pk_rtype,
  input  logic              rk_rst_en,
  input  logic [3:0]        rk_s1_sel,
  input  logic [2:0]        rk_s2_sel,
  input  logic [2:0]        rk_rtype,
  input  logic [1:0]        s3_sel,
  input  logic [HOLD_W-1:0] s3_hold_s,
  input  logic [2:0]        reason_clr,
  output logic [1:0]        key_press,
  output logic [1:0]        key_release,
  output logic [1:0]        bark,
  output logic              combo_bark,
  output logic              pon_evt,
  output logic              rst_req,
  output logic [2:0]        rst_type,
  output logic [2:0]        reason
);
  localparam int NIN = NKEY + 1;

  logic [NIN-1:0]  raw_n, sync_n;
  logic [NKEY-1:0] held, armed, key_fire;
  logic            cbl_held, cbl_prev_q, pon_q;
  logic            both_q;
  logic            s3_fire;
  key_cfg_t        cfg [NKEY];

  logic            req_d, req_q;
  logic [2:0]      type_d, type_q;
  logic [2:0]      rbit_d, reason_q, reason_d;

  assign raw_n = {cbl_pwr_n, rst_key_n, pwr_key_n};

  lpr_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(sync_n)
  );

  assign held     = ~sync_n[NKEY-1:0];
  assign cbl_held = ~sync_n[NKEY];

  assign cfg[KEY_PK] = '{rst_en: pk_rst_en, s1_sel: pk_s1_sel, s2_sel: pk_s2_sel, rtype: pk_rtype};
  assign cfg[KEY_RK] = '{rst_en: rk_rst_en, s1_sel: rk_s1_sel, s2_sel: rk_s2_sel, rtype: rk_rtype};

  genvar k;
  generate
    for (k = 0; k < NKEY; k++) begin : g_key
      lpr_key_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .held(held[k]),
        .rst_en(cfg[k].rst_en), .s1_sel(cfg[k].s1_sel), .s2_sel(cfg[k].s2_sel),
        .press_evt(key_press[k]), .release_evt(key_release[k]),
        .bark(bark[k]), .fire(key_fire[k]), .armed(armed[k])
      );
    end
  endgenerate

  lpr_s3 #(.TICKS_PER_SEC(TICKS_PER_SEC), .S3_MAX_S(S3_MAX_S), .HOLD_W(HOLD_W)) u_s3 (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .held(held),
    .sel(s3_sel), .hold_s(s3_hold_s), .fire(s3_fire)
  );

  // Both-keys warning: first cycle in which both keys are past stage 1.
  assign combo_bark = (&armed) & ~both_q;

  // Request arbitration: stage 3, then power key, then reset key.
  always_comb begin
    req_d  = 1'b0;
    type_d = type_q;
    rbit_d = 3'b000;
    if (s3_fire) begin
      req_d  = 1'b1;
      type_d = RT_HARD;
      rbit_d = 3'b100;
    end else if (key_fire[KEY_PK]) begin
      req_d  = 1'b1;
      type_d = cfg[KEY_PK].rtype;
      rbit_d = 3'b001;
    end else if (key_fire[KEY_RK]) begin
      req_d  = 1'b1;
      type_d = cfg[KEY_RK].rtype;
      rbit_d = 3'b010;
    end
    reason_d = (reason_q & ~reason_clr) | rbit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      type_q     <= '0;
      reason_q   <= '0;
      both_q     <= 1'b0;
      cbl_prev_q <= 1'b0;
      pon_q      <= 1'b0;
    end else begin
      req_q      <= req_d;
      type_q     <= type_d;
      reason_q   <= reason_d;
      both_q     <= &armed;
      cbl_prev_q <= cbl_held;
      pon_q      <= cbl_held & ~cbl_prev_q;
    end
  end

  assign rst_req  = req_q;
  assign rst_type = type_q;
  assign reason   = reason_q;
  assign pon_evt  = pon_q;
endmodule

// File: rtl/lpr_chk.sv
`timescale 1ns/1ps
module lpr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bark,
  input logic       combo_bark,
  input logic       rst_req,
  input logic [2:0] reason,
  input logic [2:0] reason_clr,
  input logic       pk_rst_en,
  input logic       s3_fire,
  input logic [1:0] key_fire
);
  // R12
  bark_pulse_pk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bark[0] |=> !bark[0]);
  // R12
  bark_pulse_rk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bark[1] |=> !bark[1]);
  // R8
  combo_with_bark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    combo_bark |-> (bark != 2'b00));
  // R9
  reason_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (reason != 3'b000));
  // R9
  reason_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reason_clr == 3'b000) |=> ((reason & $past(reason)) == $past(reason)));
  // R10
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(s3_fire || (key_fire != 2'b00)));
  // R5
  no_bark_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pk_rst_en) |-> !bark[0]);
endmodule

bind lpr_seq lpr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bark(bark), .combo_bark(combo_bark),
  .rst_req(rst_req), .reason(reason), .reason_clr(reason_clr),
  .pk_rst_en(pk_rst_en), .s3_fire(s3_fire), .key_fire(key_fire)
);

// File: tb/tb_lpr_seq.sv
`timescale 1ns/1ps
module tb_lpr_seq;
  localparam int TPS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b1;
  logic pk_n = 1'b1, rk_n = 1'b1, cb_n = 1'b1;
  logic pk_en = 1'b1, rk_en = 1'b1;
  logic [3:0] pk_s1 = '0, rk_s1 = '0;
  logic [2:0] pk_s2 = '0, rk_s2 = '0;
  logic [2:0] pk_ty = '0, rk_ty = '0;
  logic [1:0] s3_sel = 2'd0;
  logic [7:0] s3_hold = 8'd128;
  logic [2:0] rclr = '0;

  logic [1:0] key_press, key_release, bark;
  logic combo_bark, pon_evt, rst_req;
  logic [2:0] rst_type, reason;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int b0_c, b1_c, cb_c, req_c, nreq, nb0, nb1, kp_c, kr_c, pon_c;
  logic [2:0] req_ty;

  always #10 clk = ~clk;

  lpr_seq #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .pwr_key_n(pk_n), .rst_key_n(rk_n), .cbl_pwr_n(cb_n),
    .pk_rst_en(pk_en), .pk_s1_sel(pk_s1), .pk_s2_sel(pk_s2), .pk_rtype(pk_ty),
    .rk_rst_en(rk_en), .rk_s1_sel(rk_s1), .rk_s2_sel(rk_s2), .rk_rtype(rk_ty),
    .s3_sel(s3_sel), .s3_hold_s(s3_hold), .reason_clr(rclr),
    .key_press(key_press), .key_release(key_release), .bark(bark),
    .combo_bark(combo_bark), .pon_evt(pon_evt), .rst_req(rst_req),
    .rst_type(rst_type), .reason(reason)
  );

  function automatic int t1(input int i);
    int tab[16] = '{0,32,56,80,128,184,272,408,608,904,1352,2048,3072,4480,6720,10256};
    return tab[i];
  endfunction
  function automatic int t2(input int i);
    int tab[8] = '{0,10,50,100,250,500,1000,2000};
    return tab[i];
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  // Counts posedges from the caller's negedge; samples each following negedge.
  task automatic watch(input int max_cyc, input int rel_at);
    b0_c = -1; b1_c = -1; cb_c = -1; req_c = -1; kp_c = -1; kr_c = -1; pon_c = -1;
    nreq = 0; nb0 = 0; nb1 = 0; req_ty = '0;
    for (int n = 1; n <= max_cyc; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (bark[0]) begin nb0++; if (b0_c < 0) b0_c = n; end
      if (bark[1]) begin nb1++; if (b1_c < 0) b1_c = n; end
      if (combo_bark && cb_c < 0) cb_c = n;
      if (key_press != 0 && kp_c < 0) kp_c = n;
      if (key_release != 0 && kr_c < 0) kr_c = n;
      if (pon_evt && pon_c < 0) pon_c = n;
      if (rst_req) begin nreq++; if (req_c < 0) begin req_c = n; req_ty = rst_type; end end
      if (n == rel_at) begin pk_n = 1'b1; rk_n = 1'b1; end
    end
  endtask

  task automatic release_all();
    @(negedge clk);
    pk_n = 1'b1; rk_n = 1'b1; cb_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_reason(input logic [2:0] m);
    @(negedge clk); rclr = m;
    @(negedge clk); rclr = '0;
  endtask

  initial begin
    int k, s1i, s2i, tyi, rel, tot;
    int tys[4] = '{0,1,4,7};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R12 reset bark", bark, 0);
    chk("R2 reset rst_req", rst_req, 0);
    chk("R9 reset reason", reason, 0);
    chk("R11 reset pon_evt", pon_evt, 0);

    // R1/R2/R3/R12 directed: power key, longest stage 1
    pk_s1 = 4'd15; pk_s2 = 3'd0; pk_ty = 3'd4;
    pk_n = 1'b0;
    watch(10256 + 20, -1);
    chk("R1 bark idx15", b0_c, 10256 + 4);
    chk("R12 bark width", nb0, 1);
    chk("R2 req idx15/0", req_c, 10256 + 6);
    chk("R2 single req", nreq, 1);
    chk("R3 type shutdown", req_ty, 4);
    chk("R9 reason pk", reason, 1);
    release_all();

    // R4 early release then full press
    clear_reason(3'b111);
    pk_s1 = 4'd1; pk_s2 = 3'd1; pk_ty = 3'd1;
    @(negedge clk); pk_n = 1'b0;
    watch(80, 20);
    chk("R4 no req early", nreq, 0);
    chk("R4 no bark early", nb0, 0);
    @(negedge clk); pk_n = 1'b0;
    watch(60, -1);
    chk("R4 restart bark", b0_c, 36);
    chk("R4 restart req", req_c, 48);
    chk("R3 type warm", req_ty, 1);
    release_all();

    // R7 tick gating
    tick_ms = 1'b0;
    @(negedge clk); pk_n = 1'b0;
    watch(100, -1);
    chk("R7 stalled bark", nb0, 0);
    tick_ms = 1'b1;
    watch(40, -1);
    chk("R7 resume bark", b0_c, 33);
    release_all();

    // R5 enable clear, R12 events
    pk_en = 1'b0; pk_s1 = 4'd0; pk_s2 = 3'd0;
    @(negedge clk); pk_n = 1'b0;
    watch(60, -1);
    chk("R12 press evt", kp_c, 3);
    chk("R5 no bark", nb0, 0);
    chk("R5 no req", nreq, 0);
    pk_n = 1'b1;
    watch(8, -1);
    chk("R12 release evt", kr_c, 3);
    pk_en = 1'b1;
    release_all();

    // R8/R10 both keys together, equal timing
    clear_reason(3'b111);
    pk_s1 = 4'd2; pk_s2 = 3'd2; pk_ty = 3'd1;
    rk_s1 = 4'd2; rk_s2 = 3'd2; rk_ty = 3'd4;
    @(negedge clk); pk_n = 1'b0; rk_n = 1'b0;
    watch(130, -1);
    chk("R8 combo", cb_c, 60);
    chk("R8 rk bark", b1_c, 60);
    chk("R10 req", req_c, 112);
    chk("R10 single", nreq, 1);
    chk("R10 type pk", req_ty, 1);
    chk("R10 reason pk", reason, 1);
    release_all();

    // R9 sticky and W1C
    @(negedge clk); rk_n = 1'b0;
    watch(120, -1);
    chk("R9 sticky both", reason, 3);
    release_all();
    clear_reason(3'b010);
    chk("R9 w1c one bit", reason, 1);
    clear_reason(3'b000);
    chk("R9 zero write", reason, 1);
    clear_reason(3'b001);
    chk("R9 cleared", reason, 0);

    // R6 stage-3 paths (key paths disabled)
    pk_en = 1'b0; rk_en = 1'b0;
    s3_sel = 2'd2; s3_hold = 8'd3;
    @(negedge clk); pk_n = 1'b0;
    watch(50, -1);
    chk("R6 pk-only req", req_c, 34);
    chk("R6 hard type", req_ty, 7);
    chk("R6 reason", reason, 4);
    chk("R6 once", nreq, 1);
    release_all();
    s3_sel = 2'd3; s3_hold = 8'd0;
    @(negedge clk); rk_n = 1'b0;
    watch(20, -1);
    chk("R6 rk-only hold0", req_c, 4);
    release_all();
    s3_sel = 2'd1; s3_hold = 8'd1;
    @(negedge clk); rk_n = 1'b0;
    watch(30, -1);
    chk("R6 either", req_c, 14);
    release_all();
    s3_sel = 2'd0;
    @(negedge clk); pk_n = 1'b0;
    watch(40, -1);
    chk("R6 and one key", nreq, 0);
    rk_n = 1'b0;
    watch(30, -1);
    chk("R6 and both", req_c, 14);
    release_all();

    // R13 clamp
    s3_sel = 2'd2; s3_hold = 8'd200;
    @(negedge clk); pk_n = 1'b0;
    watch(1300, -1);
    chk("R13 clamp", req_c, 128 * TPS + 4);
    release_all();

    // R11 cable power
    s3_sel = 2'd0; s3_hold = 8'd128;
    @(negedge clk); cb_n = 1'b0;
    watch(50, -1);
    chk("R11 pon evt", pon_c, 3);
    chk("R11 no req", nreq, 0);
    release_all();

    // random single-key presses: R1 R2 R3 R4
    pk_en = 1'b1; rk_en = 1'b1;
    for (int it = 0; it < 12; it++) begin
      clear_reason(3'b111);
      k = $urandom_range(0, 1);
      s1i = $urandom_range(0, 11);
      s2i = $urandom_range(0, 7);
      tyi = $urandom_range(0, 3);
      tot = t1(s1i) + t2(s2i);
      rel = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2 + tot) : -1;
      @(negedge clk);
      if (k == 0) begin
        pk_s1 = 4'(s1i); pk_s2 = 3'(s2i); pk_ty = 3'(tys[tyi]); pk_n = 1'b0;
      end else begin
        rk_s1 = 4'(s1i); rk_s2 = 3'(s2i); rk_ty = 3'(tys[tyi]); rk_n = 1'b0;
      end
      watch(tot + 12, rel);
      if (rel >= 0) begin
        chk("R4 random early", nreq, 0);
      end else begin
        chk("R1 random bark", (k == 0) ? b0_c : b1_c, t1(s1i) + 4);
        chk("R2 random req", req_c, tot + 6);
        chk("R3 random type", req_ty, tys[tyi]);
        chk("R9 random reason", reason, (k == 0) ? 1 : 2);
      end
      release_all();
    end

    finish_run();
  end
endmodule